// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a memory-mapped interval timer with one interrupt line. Software reaches it through a simple 32-bit register bus. The bus has a select strobe, a write flag, a byte address inside a 32-byte window and write data. Read data is registered and appears on the cycle after the select strobe. An external one-cycle `tick_en` pulse advances the count, so the block does not need to know the real input clock or its prescaler.

In system mode the count is shown in bits 30:9 of a 32-bit word, and bits 8:0 always read as zero. When the count reaches a programmed limit, the count restarts from zero, a sticky flag in bit 31 is set and the interrupt rises. Reading the limit acknowledges the event. A processor-type instance can be switched to user mode. In user mode the same storage becomes a wide free-running counter that software can start and stop, and it is read as a high word and a low word.

Top module: `interval_timer`

## Requirements
- R1: After reset the limit reads 0x7FFFFE00, the count reads 0, the stop status reads 0 (running), the mode reads 0 (system) and `irq` is low.
- R2: In system mode each `tick_en` pulse adds 0x200 to the value read at offset 0x04, and bits 8:0 of that value always read 0.
- R3: A tick that brings the count to a value at or above the limit sets the count to 0, sets bit 31 of offset 0x04 and raises `irq` on the same clock edge. Later ticks count up again from 0.
- R4: The register index is bus address bits 4:2, and address bits 1:0 are ignored. Indexes 2, 5, 6 and 7 read as 0, and writes to them change nothing.
- R5: In system mode, reading offset 0x00 returns the limit with bit 31 clear. The same read clears the flag in bit 31 of offset 0x04 and lowers `irq`.
- R6: Writing offset 0x00 loads the limit, sets the count to 0 and lowers `irq`.
- R7: Writing offset 0x04 loads the limit and keeps the count. If the count is already at or above the new limit, the next tick triggers the R3 event.
- R8: A written limit keeps bits 30:9 of the data. If those bits are all zero, the limit becomes 0x7FFFFE00.
- R9: In user mode, offset 0x04 returns bits 31:0 and offset 0x00 returns bits 62:32 of a 63-bit value equal to tick count times 0x200. The counter does not wrap at the limit and `irq` stays low.
- R10: Offset 0x0C controls start and stop. Writing bit 0 as 1 runs the counter and writing 0 stops it. A read returns 1 while stopped. A stopped counter ignores ticks in user mode.
- R11: Offset 0x10 bit 0 selects user mode (1) or system mode (0) and reads back the mode. Only an instance built with IS_PROC=1 accepts the write. An accepted write clears the count, the flag and `irq`.
- R12: If a limit read and a limit-reaching tick fall on the same edge, the new event wins: `irq` and the flag end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count-advance pulse |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Interrupt, level high |

## Verification
Every register side effect and every tick lands on the same edge that samples the strobe or pulse. So `irq` and the internal count are checked at the falling edge just after that rising edge. Read data is registered and carries the state from before the edge. The scoreboard queues each expected word when the strobe is driven, and pops it at the falling edge of the next cycle, when a flopped "read issued" marker is set. That keeps every comparison one cycle after its request. The same-edge case in R12 drives a tick and a limit read together. It expects the old limit on the data bus and a set flag afterwards.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      IX_LIMIT = 3'd0,
      IX_COUNT = 3'd1,
      IX_RSV2  = 3'd2,
      IX_RUN   = 3'd3,
      IX_MODE  = 3'd4,
      IX_RSV5  = 3'd5,
      IX_RSV6  = 3'd6,
      IX_RSV7  = 3'd7
   } reg_ix_e;

   typedef struct packed {
      logic wr_lim_clr;   // load limit, clear count
      logic wr_lim_keep;  // load limit, keep count
      logic wr_run;       // start/stop control write
      logic wr_mode;      // mode select write
      logic rd_lim;       // limit read (acknowledge)
   } tmr_ctl_t;
endpackage

// File: rtl/tmr_addr_dec.sv
`timescale 1ns/1ps
module tmr_addr_dec
   import tmr_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output reg_ix_e           ix,
   output tmr_ctl_t          ctl
);
   if (ADDR_W - 2 != IDX_W) begin : g_bad_addr_w
      $error("tmr_addr_dec: ADDR_W must give exactly IDX_W index bits");
   end

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr[1:0];

   assign ix = reg_ix_e'(addr[ADDR_W-1:2]);

   always_comb begin
      ctl             = '0;
      ctl.wr_lim_clr  = sel &&  wr && (ix == IX_LIMIT);
      ctl.wr_lim_keep = sel &&  wr && (ix == IX_COUNT);
      ctl.wr_run      = sel &&  wr && (ix == IX_RUN);
      ctl.wr_mode     = sel &&  wr && (ix == IX_MODE);
      ctl.rd_lim      = sel && !wr && (ix == IX_LIMIT);
   end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_LSB = 9,
   parameter int LIM_W   = 22,
   parameter int UCNT_W  = 54,
   parameter bit IS_PROC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  tmr_ctl_t          ctl,
   input  logic [DATA_W-1:0] wdata,
   output logic [UCNT_W-1:0] ucnt,
   output logic [LIM_W-1:0]  lim,
   output logic              reached,
   output logic              irq,
   output logic              user_mode,
   output logic              stopped
);
   localparam int HI_W = UCNT_W - LIM_W;

   if (LIM_W + CNT_LSB + 1 != DATA_W) begin : g_bad_lim_w
      $error("tmr_count_core: LIM_W + CNT_LSB + 1 must equal DATA_W");
   end
   if (HI_W < 1) begin : g_bad_ucnt_w
      $error("tmr_count_core: user counter must be wider than the limit");
   end

   // limit from write data: keep the count field, zero means maximum
   logic [LIM_W-1:0] lim_field, lim_new;
   logic             unused_wdata_bits;
   assign lim_field = wdata[DATA_W-2:CNT_LSB];
   assign lim_new   = (lim_field == '0) ? '1 : lim_field;
   assign unused_wdata_bits = ^{wdata[DATA_W-1], wdata[CNT_LSB-1:1]};

   // mode write acceptance depends on the instance kind
   logic mode_wr;
   if (IS_PROC) begin : g_proc
      assign mode_wr = ctl.wr_mode;
   end else begin : g_fixed
      assign mode_wr = 1'b0;
   end

   logic [LIM_W:0] sys_inc;
   logic           hit;
   assign sys_inc = {1'b0, ucnt[LIM_W-1:0]} + 1'b1;
   assign hit     = tick_en && !user_mode && !ctl.wr_lim_clr && !mode_wr
                    && (sys_inc >= {1'b0, lim});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ucnt      <= '0;
         lim       <= '1;
         reached   <= 1'b0;
         irq       <= 1'b0;
         user_mode <= 1'b0;
         stopped   <= 1'b0;
      end else begin
         // counter
         if (ctl.wr_lim_clr || mode_wr) begin
            ucnt <= '0;
         end else if (tick_en) begin
            if (user_mode) begin
               if (!stopped) ucnt <= ucnt + 1'b1;
            end else if (hit) begin
               ucnt <= '0;
            end else begin
               ucnt <= {{HI_W{1'b0}}, sys_inc[LIM_W-1:0]};
            end
         end
         // limit
         if (ctl.wr_lim_clr || ctl.wr_lim_keep) lim <= lim_new;
         // sticky flag
         if (mode_wr)                           reached <= 1'b0;
         else if (hit)                          reached <= 1'b1;
         else if (ctl.rd_lim && !user_mode)     reached <= 1'b0;
         // interrupt
         if (mode_wr || ctl.wr_lim_clr)         irq <= 1'b0;
         else if (hit)                          irq <= 1'b1;
         else if (ctl.rd_lim && !user_mode)     irq <= 1'b0;
         // run control and mode
         if (ctl.wr_run) stopped   <= !wdata[0];
         if (mode_wr)    user_mode <= wdata[0];
      end
   end
endmodule

// File: rtl/tmr_read_mux.sv
`timescale 1ns/1ps
module tmr_read_mux
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_LSB = 9,
   parameter int LIM_W   = 22,
   parameter int UCNT_W  = 54
) (
   input  reg_ix_e           ix,
   input  logic              user_mode,
   input  logic              stopped,
   input  logic              reached,
   input  logic [LIM_W-1:0]  lim,
   input  logic [UCNT_W-1:0] ucnt,
   output logic [DATA_W-1:0] rval
);
   localparam int USR_W = UCNT_W + CNT_LSB;

   logic [USR_W-1:0]  uval;
   logic [DATA_W-1:0] u_hi, u_lo, s_lim, s_cnt;

   assign uval  = {ucnt, {CNT_LSB{1'b0}}};
   assign u_hi  = DATA_W'(uval >> DATA_W) & {1'b0, {(DATA_W-1){1'b1}}};
   assign u_lo  = uval[DATA_W-1:0];
   assign s_lim = {1'b0, lim, {CNT_LSB{1'b0}}};
   assign s_cnt = {reached, ucnt[LIM_W-1:0], {CNT_LSB{1'b0}}};

   always_comb begin
      unique case (ix)
         IX_LIMIT: rval = user_mode ? u_hi : s_lim;
         IX_COUNT: rval = user_mode ? u_lo : s_cnt;
         IX_RUN:   rval = {{(DATA_W-1){1'b0}}, stopped};
         IX_MODE:  rval = {{(DATA_W-1){1'b0}}, user_mode};
         default:  rval = '0;
      endcase
   end
endmodule

// File: rtl/interval_timer.sv
`timescale 1ns/1ps
module interval_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int CNT_LSB = 9,
   parameter int SYS_W   = 31,
   parameter int USR_W   = 63,
   parameter bit IS_PROC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int LIM_W  = SYS_W - CNT_LSB;
   localparam int UCNT_W = USR_W - CNT_LSB;

   if (SYS_W + 1 != DATA_W) begin : g_bad_sys_w
      $error("interval_timer: SYS_W must be DATA_W-1");
   end
   if (USR_W > 2*DATA_W - 1 || USR_W <= SYS_W) begin : g_bad_usr_w
      $error("interval_timer: USR_W out of range");
   end

   reg_ix_e           ix;
   tmr_ctl_t          ctl;
   logic [UCNT_W-1:0] ucnt_q;
   logic [LIM_W-1:0]  lim_q;
   logic              reached_q, user_mode_q, stopped_q;
   logic [DATA_W-1:0] rval;

   tmr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .sel (bus_sel), .wr (bus_wr), .addr (bus_addr), .ix (ix), .ctl (ctl)
   );

   tmr_count_core #(
      .DATA_W (DATA_W), .CNT_LSB (CNT_LSB), .LIM_W (LIM_W),
      .UCNT_W (UCNT_W), .IS_PROC (IS_PROC)
   ) u_core (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .ctl (ctl),
      .wdata (bus_wdata), .ucnt (ucnt_q), .lim (lim_q),
      .reached (reached_q), .irq (irq), .user_mode (user_mode_q),
      .stopped (stopped_q)
   );

   tmr_read_mux #(
      .DATA_W (DATA_W), .CNT_LSB (CNT_LSB), .LIM_W (LIM_W), .UCNT_W (UCNT_W)
   ) u_rmux (
      .ix (ix), .user_mode (user_mode_q), .stopped (stopped_q),
      .reached (reached_q), .lim (lim_q), .ucnt (ucnt_q), .rval (rval)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rval;
   end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5,
   parameter int CNT_LSB = 9,
   parameter int LIM_W   = 22,
   parameter int UCNT_W  = 54
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              reached,
   input logic [LIM_W-1:0]  lim,
   input logic [UCNT_W-1:0] ucnt,
   input logic              user_mode,
   input logic              stopped
);
   logic rd0, rd1, wr0;
   assign rd0 = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == 3'd0);
   assign rd1 = bus_sel && !bus_wr && (bus_addr[ADDR_W-1:2] == 3'd1);
   assign wr0 = bus_sel &&  bus_wr && (bus_addr[ADDR_W-1:2] == 3'd0);

   p_irq_has_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> reached);

   p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd1 |=> (bus_rdata[CNT_LSB-1:0] == '0));

   p_limit_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lim != '0);

   p_read_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0 && !user_mode && !tick_en) |=> (!irq && !reached));

   p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr0 |=> (!irq && ucnt == '0));

   p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && stopped && !(bus_sel && bus_wr)) |=> $stable(ucnt));

   p_user_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> !irq);
endmodule

bind interval_timer tmr_checker #(
   .DATA_W (DATA_W), .ADDR_W (ADDR_W), .CNT_LSB (CNT_LSB),
   .LIM_W (LIM_W), .UCNT_W (UCNT_W)
) i_chk (
   .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .bus_sel (bus_sel),
   .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_rdata (bus_rdata),
   .irq (irq), .reached (reached_q), .lim (lim_q), .ucnt (ucnt_q),
   .user_mode (user_mode_q), .stopped (stopped_q)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_fx;
   logic        irq, irq_fx;

   always #5 clk = ~clk;

   interval_timer i_interval_timer (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .bus_sel (sel),
      .bus_wr (wr), .bus_addr (addr), .bus_wdata (wdata),
      .bus_rdata (rdata), .irq (irq)
   );

   // non-processor instance: mode writes must be refused
   interval_timer #(.IS_PROC(1'b0)) i_fixed (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en), .bus_sel (sel),
      .bus_wr (wr), .bus_addr (addr), .bus_wdata (wdata),
      .bus_rdata (rdata_fx), .irq (irq_fx)
   );

   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;
   logic [31:0] q_val[$];
   string       q_tag[$];
   logic        rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= sel && !wr;

   // monitor: one expected word per completed read
   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (q_val.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: read data %h with no expectation", rdata);
         end else begin
            automatic logic [31:0] e = q_val.pop_front();
            automatic string       t = q_tag.pop_front();
            if (rdata !== e) begin
               fails++;
               $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
            end
         end
      end
   end

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string t);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      q_val.push_back(e); q_tag.push_back(t);
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
      end
      @(negedge clk); tick_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 32'h0);
      bus_rd(5'h00, 32'h7FFF_FE00, "R1 limit");
      bus_rd(5'h04, 32'h0, "R1 count");
      bus_rd(5'h0C, 32'h0, "R1 run status");
      bus_rd(5'h10, 32'h0, "R1 mode");

      // R2 tick stepping
      ticks(3);
      bus_rd(5'h04, 32'h0000_0600, "R2 three ticks");

      // R6 limit write clears count
      bus_wr(5'h00, 32'h0000_0800);
      bus_rd(5'h04, 32'h0, "R6 count cleared");
      chk("R6 irq", {31'b0, irq}, 32'h0);

      // R3 reaching the limit
      ticks(3);
      bus_rd(5'h04, 32'h0000_0600, "R3 below limit");
      chk("R3 irq low", {31'b0, irq}, 32'h0);
      ticks(1);
      chk("R3 irq high", {31'b0, irq}, 32'h1);
      bus_rd(5'h04, 32'h8000_0000, "R3 flag and wrap");

      // R5 acknowledge
      bus_rd(5'h00, 32'h0000_0800, "R5 limit read");
      chk("R5 irq cleared", {31'b0, irq}, 32'h0);
      bus_rd(5'h04, 32'h0, "R5 flag cleared");
      ticks(2);
      bus_rd(5'h04, 32'h0000_0400, "R3 restart count");

      // R7 limit write keeping the count
      bus_wr(5'h00, 32'h0000_1000);
      ticks(5);
      bus_rd(5'h04, 32'h0000_0A00, "R7 before");
      bus_wr(5'h04, 32'h0000_0600);
      bus_rd(5'h04, 32'h0000_0A00, "R7 count kept");
      bus_rd(5'h00, 32'h0000_0600, "R7 new limit");
      ticks(1);
      chk("R7 overshoot fires", {31'b0, irq}, 32'h1);
      bus_rd(5'h04, 32'h8000_0000, "R7 wrapped");
      bus_rd(5'h00, 32'h0000_0600, "R7 ack");

      // R8 masking and zero limit
      bus_wr(5'h00, 32'h0000_01FF);
      bus_rd(5'h00, 32'h7FFF_FE00, "R8 zero field");
      bus_wr(5'h00, 32'hFFFF_FFFF);
      bus_rd(5'h00, 32'h7FFF_FE00, "R8 all ones");
      bus_wr(5'h04, 32'h8000_0C00);
      bus_rd(5'h00, 32'h0000_0C00, "R8 bit31 dropped");

      // R4 decode and unused offsets
      bus_rd(5'h03, 32'h0000_0C00, "R4 low bits ignored");
      bus_wr(5'h08, 32'h1234_5678);
      bus_wr(5'h14, 32'hFFFF_FFFF);
      bus_wr(5'h1C, 32'h0000_0001);
      bus_rd(5'h08, 32'h0, "R4 idx2");
      bus_rd(5'h14, 32'h0, "R4 idx5");
      bus_rd(5'h1C, 32'h0, "R4 idx7");
      bus_rd(5'h00, 32'h0000_0C00, "R4 limit untouched");
      bus_rd(5'h04, 32'h0, "R4 count untouched");
      bus_rd(5'h10, 32'h0, "R4 mode untouched");
      bus_rd(5'h0C, 32'h0, "R4 run untouched");

      // R12 tick reaching limit on the same edge as a limit read
      bus_wr(5'h00, 32'h0000_0800);
      ticks(3);
      @(negedge clk);
      tick_en = 1'b1; sel = 1'b1; wr = 1'b0; addr = 5'h00;
      q_val.push_back(32'h0000_0800); q_tag.push_back("R12 old limit");
      @(negedge clk);
      tick_en = 1'b0; sel = 1'b0;
      chk("R12 irq kept", {31'b0, irq}, 32'h1);
      bus_rd(5'h04, 32'h8000_0000, "R12 flag kept");
      bus_rd(5'h00, 32'h0000_0800, "R12 ack");

      // R11 mode switch, R9 user counting
      bus_wr(5'h10, 32'h0000_0001);
      bus_rd(5'h10, 32'h1, "R11 mode set");
      chk("R11 fixed instance refuses", rdata_fx, 32'h0);
      bus_rd(5'h04, 32'h0, "R11 reload");
      ticks(3);
      bus_rd(5'h04, 32'h0000_0600, "R9 low word");
      bus_rd(5'h00, 32'h0, "R9 high word");

      // R10 stop and start
      bus_wr(5'h0C, 32'h0);
      bus_rd(5'h0C, 32'h1, "R10 stopped status");
      ticks(2);
      bus_rd(5'h04, 32'h0000_0600, "R10 held while stopped");
      bus_wr(5'h0C, 32'h1);
      bus_rd(5'h0C, 32'h0, "R10 running status");
      ticks(5);
      bus_rd(5'h04, 32'h0000_1000, "R9 passes limit");
      chk("R9 no irq", {31'b0, irq}, 32'h0);

      // R11 back to system mode
      bus_wr(5'h10, 32'h0);
      bus_rd(5'h10, 32'h0, "R11 mode cleared");
      bus_rd(5'h04, 32'h0, "R11 reload again");

      repeat (3) @(negedge clk);
      chk("scoreboard drained", q_val.size(), 32'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule